// File: doc/BRIEF.md
# Clock Status and Event Notification Register Unit

This unit is the register block of an audio streaming interface that tells a host how the sample clock is doing. It holds a 64-bit owner address, an event word, a status word for the current clock source, and an extended status word with one lock bit and one slip flag per clock source. It also holds a clock-select register and a stream-enable register. The unit watches the lock inputs from the clock recovery logic. When any watched input changes, or when the host writes the clock-select register, it records the new set of events and issues a one-cycle notification request that carries the owner address and the new event word.

The host reaches the registers through a simple request/response port. A request carries an operation, a register index, write data and a compare operand. Operation 1 is a write, operation 2 is a compare-and-swap, and any other value is a quadlet read. Register indices are: 0 owner, 1 event word, 2 clock select, 3 enable, 4 current status, 5 extended status. Indices 6 and 7 read as zero. Each request gets a response in the next cycle. A bus-reset input puts the owner register back to the no-owner value and stops streaming.

Top module: `clk_evt_regs`

## Requirements
- R1: After reset or a bus_reset pulse, the owner register reads 0xFFFF_0000_0000_0000, which is the no-owner value. A plain write to index 0 leaves the owner unchanged.
- R2: A compare-and-swap to index 0 returns the old owner value. It loads req_wdata only when req_cmp equals that old value.
- R3: In a cycle that has at least one event, the event word (index 1) is replaced by exactly that cycle's events. The bit encodings are: bit 0 receive configuration changed (rx_cfg_chg), bit 1 transmit configuration changed (tx_cfg_chg), bit 4 current-source lock changed, bit 5 clock select written, bit 6 lock of any source changed. Cycles with no event leave the word as it is.
- R4: One cycle after an event cycle, notify_valid pulses for one cycle. The pulse carries the owner value (notify_addr) and the new event word (notify_word). There is no pulse while the owner is the no-owner value, and none in a bus_reset cycle.
- R5: Extended status bits 10:0 follow src_locked, delayed by one register. Any change in src_locked is an event with bit 6 set.
- R6: Extended status bits 16 to 26 are sticky slip flags for the same sources, in the same order. A src_slip bit sets its flag and raises no event. A quadlet read of index 5 returns the flags and then clears them. A slip that arrives in the same cycle as that read stays set.
- R7: bus_reset sets stream_run to zero. Writing zero to index 3 stops all streams. Writing a nonzero value sets stream_run to chan_valid, so only streams with a valid channel start.
- R8: A write to index 2 loads clock_sel from write bits 15:0 (source in 7:0, rate code in 15:8) and raises event bit 5. The reset value of clock_sel is 0x020C.
- R9: rsp_valid follows req_valid one cycle later. The response data is the register value for a read or compare-and-swap, zero for a write, and zero for indices 6 and 7.
- R10: Status bit 0 (index 4) follows cur_locked, delayed by one register. A change in cur_locked is an event with bit 4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Bus reset pulse |
| req_valid | input | 1 | Host request strobe |
| req_op | input | 2 | 1 write, 2 compare-and-swap, else read |
| req_idx | input | AW | Register index |
| req_wdata | input | 64 | Write or swap data |
| req_cmp | input | 64 | Compare operand |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Response data |
| rx_cfg_chg | input | 1 | Receive configuration change pulse |
| tx_cfg_chg | input | 1 | Transmit configuration change pulse |
| cur_locked | input | 1 | Lock state of the current source |
| src_locked | input | NSRC | Lock state per source |
| src_slip | input | NSRC | Slip error pulse per source |
| chan_valid | input | NSTR | Stream has a valid channel |
| stream_run | output | NSTR | Streams running |
| clock_sel | output | 16 | Clock select register |
| notify_valid | output | 1 | Notification request pulse |
| notify_addr | output | 64 | Notification target address |
| notify_word | output | 32 | Event word to send |

## Verification
The hardest case to reach is the race between a slip error and the read that clears the slip flags. It only shows up when src_slip pulses in exactly the cycle of a quadlet read of index 5. The stimulus builds that cycle on purpose and then reads again to confirm the flag survived. A long random phase also puts compare-and-swap operations, with matching and non-matching operands, next to bus_reset pulses and event bursts. This checks owner gating of the notification pulse. A behavioural model runs alongside and is compared against the outputs every cycle.

// File: rtl/clk_evt_regs.sv
`timescale 1ns/1ps
module clk_evt_regs #(
  parameter int NSRC = 11,
  parameter int NSTR = 4,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_idx,
  input  logic [63:0]     req_wdata,
  input  logic [63:0]     req_cmp,
  output logic            rsp_valid,
  output logic [63:0]     rsp_data,
  input  logic            rx_cfg_chg,
  input  logic            tx_cfg_chg,
  input  logic            cur_locked,
  input  logic [NSRC-1:0] src_locked,
  input  logic [NSRC-1:0] src_slip,
  input  logic [NSTR-1:0] chan_valid,
  output logic [NSTR-1:0] stream_run,
  output logic [15:0]     clock_sel,
  output logic            notify_valid,
  output logic [63:0]     notify_addr,
  output logic [31:0]     notify_word
);
  localparam logic [63:0] NO_OWNER = 64'hFFFF_0000_0000_0000;
  localparam int SLIP_LSB = 16;
  localparam logic [15:0] CLK_RST = 16'h020C;

  logic [63:0]     owner_q;
  logic [31:0]     evt_q, en_q;
  logic [NSRC-1:0] lock_q, slip_q;
  logic            cur_q;
  logic [31:0]     ext_word, ev;
  logic [63:0]     rd_val;

  wire is_wr  = req_valid && req_op == 2'd1;
  wire is_cas = req_valid && req_op == 2'd2;
  wire is_rd  = req_valid && !is_wr && !is_cas;
  wire clk_acc = is_wr && req_idx == AW'(2);
  wire slip_clr = is_rd && req_idx == AW'(5);

  always_comb begin
    ext_word = '0;
    ext_word[NSRC-1:0] = lock_q;
    ext_word[SLIP_LSB +: NSRC] = slip_q;
  end

  assign ev = {25'd0, src_locked != lock_q, clk_acc, cur_locked != cur_q,
               2'b00, tx_cfg_chg, rx_cfg_chg};

  always_comb begin
    case (req_idx)
      AW'(0):  rd_val = owner_q;
      AW'(1):  rd_val = {32'd0, evt_q};
      AW'(2):  rd_val = {48'd0, clock_sel};
      AW'(3):  rd_val = {32'd0, en_q};
      AW'(4):  rd_val = {63'd0, cur_q};
      AW'(5):  rd_val = {32'd0, ext_word};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= NO_OWNER;
      evt_q <= '0;
      en_q <= '0;
      stream_run <= '0;
      clock_sel <= CLK_RST;
      lock_q <= '0;
      slip_q <= '0;
      cur_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
      notify_valid <= 1'b0;
      notify_addr <= '0;
      notify_word <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_data <= is_wr ? 64'd0 : rd_val;
      lock_q <= src_locked;
      cur_q <= cur_locked;
      slip_q <= (slip_q & ~{NSRC{slip_clr}}) | src_slip;
      notify_valid <= (|ev) && owner_q != NO_OWNER && !bus_reset;
      if (|ev) begin
        evt_q <= ev;
        notify_addr <= owner_q;
        notify_word <= ev;
      end
      if (clk_acc) clock_sel <= req_wdata[15:0];
      if (bus_reset) begin
        owner_q <= NO_OWNER;
        en_q <= '0;
        stream_run <= '0;
      end else begin
        if (is_cas && req_idx == AW'(0) && req_cmp == owner_q) owner_q <= req_wdata;
        if (is_wr && req_idx == AW'(3)) begin
          en_q <= req_wdata[31:0];
          stream_run <= (|req_wdata[31:0]) ? chan_valid : '0;
        end
      end
    end
  end
endmodule

module clk_evt_regs_chk #(
  parameter int NSRC = 11,
  parameter int NSTR = 4,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_reset,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic [AW-1:0]   req_idx,
  input logic [63:0]     req_cmp,
  input logic            rsp_valid,
  input logic [NSRC-1:0] src_slip,
  input logic [NSTR-1:0] stream_run,
  input logic            notify_valid,
  input logic [63:0]     notify_addr,
  input logic [63:0]     owner_q,
  input logic [NSRC-1:0] slip_q
);
  localparam logic [63:0] NO_OWNER = 64'hFFFF_0000_0000_0000;

  p_owner_busrst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> owner_q == NO_OWNER);
  p_cas_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && req_idx == '0 && req_cmp != owner_q && !bus_reset)
      |=> $stable(owner_q));
  p_notify_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> notify_addr != NO_OWNER);
  p_notify_busrst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !notify_valid);
  p_slip_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_slip) |=> ((slip_q & $past(src_slip)) == $past(src_slip)));
  p_run_busrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> stream_run == '0);
  p_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

bind clk_evt_regs clk_evt_regs_chk #(.NSRC(NSRC), .NSTR(NSTR), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
  .req_op(req_op), .req_idx(req_idx), .req_cmp(req_cmp), .rsp_valid(rsp_valid),
  .src_slip(src_slip), .stream_run(stream_run), .notify_valid(notify_valid),
  .notify_addr(notify_addr), .owner_q(owner_q), .slip_q(slip_q));

// File: tb/clk_evt_regs_tb.sv
`timescale 1ns/1ps
module clk_evt_regs_tb_top;
  localparam int NSRC = 11, NSTR = 4, AW = 3;
  localparam logic [63:0] NOO = 64'hFFFF_0000_0000_0000;

  logic clk = 0, rst_n = 0, bus_reset = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_idx = 0;
  logic [63:0] req_wdata = 0, req_cmp = 0;
  logic rx_cfg_chg = 0, tx_cfg_chg = 0, cur_locked = 0;
  logic [NSRC-1:0] src_locked = 0, src_slip = 0;
  logic [NSTR-1:0] chan_valid = 0;
  logic rsp_valid, notify_valid;
  logic [63:0] rsp_data, notify_addr;
  logic [NSTR-1:0] stream_run;
  logic [15:0] clock_sel;
  logic [31:0] notify_word;

  always #2.5 clk = ~clk;

  clk_evt_regs #(.NSRC(NSRC), .NSTR(NSTR), .AW(AW)) dut_i (.*);

  int checks = 0, fails = 0;
  logic [63:0] m_owner, m_rspd, m_na;
  logic [31:0] m_evt, m_en, m_nw;
  logic [15:0] m_clk;
  logic [NSRC-1:0] m_lock, m_slip;
  logic [NSTR-1:0] m_run;
  logic m_cur, m_rspv, m_nv;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_owner = NOO; m_evt = 0; m_en = 0; m_run = 0; m_clk = 16'h020C;
    m_lock = 0; m_slip = 0; m_cur = 0; m_rspv = 0; m_rspd = 0;
    m_nv = 0; m_na = 0; m_nw = 0;
  endtask

  task automatic compare(string tag);
    chk(tag, "rsp_valid", 64'(rsp_valid), 64'(m_rspv));
    if (m_rspv) chk(tag, "rsp_data", rsp_data, m_rspd);
    chk(tag, "notify_valid", 64'(notify_valid), 64'(m_nv));
    if (m_nv) begin
      chk(tag, "notify_addr", notify_addr, m_na);
      chk(tag, "notify_word", 64'(notify_word), 64'(m_nw));
    end
    chk(tag, "stream_run", 64'(stream_run), 64'(m_run));
    chk(tag, "clock_sel", 64'(clock_sel), 64'(m_clk));
  endtask

  task automatic tick(string tag);
    logic wr, cas, rd;
    logic [31:0] ev, ext;
    logic [63:0] v;
    wr = req_valid && req_op == 1;
    cas = req_valid && req_op == 2;
    rd = req_valid && !wr && !cas;
    ext = 0;
    for (int i = 0; i < NSRC; i++) begin
      ext[i] = m_lock[i];
      ext[16+i] = m_slip[i];
    end
    case (req_idx)
      0: v = m_owner;
      1: v = {32'd0, m_evt};
      2: v = {48'd0, m_clk};
      3: v = {32'd0, m_en};
      4: v = {63'd0, m_cur};
      5: v = {32'd0, ext};
      default: v = 0;
    endcase
    ev = 0;
    if (rx_cfg_chg) ev |= 32'h1;
    if (tx_cfg_chg) ev |= 32'h2;
    if (cur_locked != m_cur) ev |= 32'h10;
    if (wr && req_idx == 2) ev |= 32'h20;
    if (src_locked != m_lock) ev |= 32'h40;
    m_rspv = req_valid;
    m_rspd = wr ? 0 : v;
    m_nv = (ev != 0) && m_owner != NOO && !bus_reset;
    if (ev != 0) begin m_evt = ev; m_na = m_owner; m_nw = ev; end
    if (rd && req_idx == 5) m_slip = 0;
    m_slip |= src_slip;
    m_lock = src_locked;
    m_cur = cur_locked;
    if (wr && req_idx == 2) m_clk = req_wdata[15:0];
    if (bus_reset) begin
      m_owner = NOO; m_en = 0; m_run = 0;
    end else begin
      if (cas && req_idx == 0 && req_cmp == m_owner) m_owner = req_wdata;
      if (wr && req_idx == 3) begin
        m_en = req_wdata[31:0];
        m_run = (req_wdata[31:0] != 0) ? chan_valid : 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic req(string tag, logic [1:0] op, int idx, logic [63:0] wd, logic [63:0] cmp);
    req_valid = 1; req_op = op; req_idx = AW'(idx); req_wdata = wd; req_cmp = cmp;
    tick(tag);
    req_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R9 watchdog expired: actual hang expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 R8 reset state");
    rst_n = 1;
    tick("R9 idle");
    req("R1 R9 read owner", 0, 0, 0, 0);
    req("R9 read unmapped", 0, 7, 0, 0);
    req("R1 write owner ignored", 1, 0, 64'h1234, 0);
    req("R1 owner readback", 0, 0, 0, 0);
    req("R2 cas miss", 2, 0, 64'hABCD, 64'h5);
    req("R2 cas hit", 2, 0, 64'h0000_FFC0_0000_1000, NOO);
    req("R2 owner readback", 0, 0, 0, 0);
    rx_cfg_chg = 1; tick("R3 R4 rx event"); rx_cfg_chg = 0;
    tick("R4 pulse ends");
    rx_cfg_chg = 1; tx_cfg_chg = 1; tick("R3 two events"); rx_cfg_chg = 0; tx_cfg_chg = 0;
    req("R3 event word read", 0, 1, 0, 0);
    cur_locked = 1; tick("R10 cur lock change");
    req("R10 status read", 0, 4, 0, 0);
    src_locked = 11'h041; tick("R5 lock change");
    req("R5 ext read", 0, 5, 0, 0);
    req("R8 clock select write", 1, 2, 64'h0401, 0);
    req("R8 clock select read", 0, 2, 0, 0);
    src_slip = 11'h008; tick("R6 slip no event"); src_slip = 0;
    req("R6 ext read with slip", 0, 5, 0, 0);
    req("R6 ext read cleared", 0, 5, 0, 0);
    src_slip = 11'h400;
    req("R6 slip during clearing read", 0, 5, 0, 0);
    src_slip = 0;
    req("R6 slip survived", 0, 5, 0, 0);
    req("R6 cas on ext keeps slip", 2, 5, 0, 0);
    chan_valid = 4'b0101;
    req("R7 enable nonzero", 1, 3, 64'h1, 0);
    req("R7 enable zero", 1, 3, 64'h0, 0);
    req("R7 enable again", 1, 3, 64'h8, 0);
    bus_reset = 1; tx_cfg_chg = 1; tick("R7 R4 bus reset"); bus_reset = 0; tx_cfg_chg = 0;
    req("R1 owner after bus reset", 0, 0, 0, 0);
    rx_cfg_chg = 1; tick("R4 no owner no pulse"); rx_cfg_chg = 0;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      rx_cfg_chg = (r[3:0] == 0);
      tx_cfg_chg = (r[7:4] == 0);
      if (r[11:8] == 0) cur_locked = ~cur_locked;
      if (r[15:12] == 0) src_locked = NSRC'($urandom);
      src_slip = (r[19:16] == 0) ? NSRC'(1 << (r[23:20] % NSRC)) : '0;
      bus_reset = (r[31:26] == 0);
      chan_valid = NSTR'($urandom);
      req_valid = r[24];
      req_op = 2'($urandom);
      req_idx = AW'($urandom);
      req_wdata = r[25] ? 64'(r) : NOO;
      req_cmp = r[5] ? m_owner : NOO;
      tick("R2 R3 R4 R6 R7 random");
    end
    req_valid = 0; bus_reset = 0; rx_cfg_chg = 0; tx_cfg_chg = 0; src_slip = 0;
    tick("R9 drain");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule